// File: doc/BRIEF.md
# Address Space Privilege Checker

The block sits between a processor core and its memory system and judges every memory request by the 8-bit space identifier that travels with the 26-bit address. It keeps a one-bit privilege mode, supervisor or user. Reset and trap entry force supervisor mode. A trap return restores the mode that the most recent trap entry saved. Only two identifier values, one for user instructions and one for user data, are open in user mode. Every other value is for the supervisor only.

The result of a request appears one clock after its strobe. The block raises either a grant or a protection violation, together with at most one region strobe. The strobe routes the access to user instruction space, user data space, the peripheral control registers, the cache tag array, the cache data array, or one of four application-defined spaces. When a request is granted, its address and write flag are registered alongside the grant so that the downstream memory sees a stable access.

Top module: `asi_guard`

## Requirements
- R1: While rst_ni is low and on its release, super_o is 1, grant_o and viol_o are 0, all region strobes are 0, addr_o is 0, we_o is 0, and the saved mode is cleared to user (0).
- R2: Outputs are registered. grant_o, viol_o and the strobes describe the request sampled at the previous rising edge. A cycle with req_i low gives grant_o=0, viol_o=0 and no strobe.
- R3: A request made while in supervisor mode is granted for every identifier value 0x00 to 0xFF, and viol_o stays 0.
- R4: A request made while in user mode is granted for identifier 0x08 with sel_uinst_o=1, and for identifier 0x09 with sel_udata_o=1.
- R5: A request made while in user mode with any identifier other than 0x08 or 0x09 gives grant_o=0 and viol_o=1 for one cycle, and no region strobe.
- R6: On a granted request, the strobes decode as follows: 0x04 gives sel_periph_o, 0x0C gives sel_ctag_o, 0x0D gives sel_cdata_o, and 0x20 to 0x23 give sel_app_o. 0x08 and 0x09 give the user strobes. Every other value, including 0x0A and 0x0B, gives no strobe. At most one strobe is high at a time.
- R7: A trap_i pulse sets super_o to 1 from the next cycle and saves the mode held before the pulse.
- R8: A rett_i pulse without trap_i sets super_o to the saved mode from the next cycle. After reset this means user mode.
- R9: When trap_i and rett_i are high in the same cycle, trap entry wins.
- R10: A request in the same cycle as a mode change is judged with the mode held before that edge.
- R11: addr_o and we_o take addr_i and we_i only on a granted request. On a violation or an idle cycle they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | Write flag (1 = write) |
| addr_i | input | 26 | Request address |
| asi_i | input | 8 | Space identifier |
| trap_i | input | 1 | Trap entry pulse |
| rett_i | input | 1 | Return-from-trap pulse |
| grant_o | output | 1 | Request granted |
| viol_o | output | 1 | Protection violation |
| super_o | output | 1 | Current mode, 1 = supervisor |
| addr_o | output | 26 | Address of the last granted request |
| we_o | output | 1 | Write flag of the last granted request |
| sel_uinst_o | output | 1 | User instruction space strobe |
| sel_udata_o | output | 1 | User data space strobe |
| sel_periph_o | output | 1 | Peripheral register strobe |
| sel_ctag_o | output | 1 | Cache tag array strobe |
| sel_cdata_o | output | 1 | Cache data array strobe |
| sel_app_o | output | 1 | Application-defined space strobe |

## Verification
The bench probes the two edges of the application range, 0x20 and 0x23, and the values just outside it. A decoder with an off-by-one range would either strobe 0x24 or miss 0x23. It sends user requests to supervisor identifiers next to the open pair, such as 0x07 and 0x0A, and to supervisor regions. A design that leaked privilege would grant these or let a region strobe fire with the violation. It places requests in the same cycle as trap entry and trap return, raises both pulses together, and returns from a trap taken in supervisor mode. A design that used the new mode too early, let the return win, or restored a fixed mode would show the wrong grant or the wrong super_o. A reset in the middle of the run checks that the saved mode clears, so that a following return drops to user mode.

// File: rtl/asi_guard_pkg.sv
package asi_guard_pkg;

  typedef enum logic [2:0] {
    RGN_NONE   = 3'd0,
    RGN_UINST  = 3'd1,
    RGN_UDATA  = 3'd2,
    RGN_PERIPH = 3'd3,
    RGN_CTAG   = 3'd4,
    RGN_CDATA  = 3'd5,
    RGN_APP    = 3'd6
  } region_e;

  localparam int unsigned NUM_STROBES = 6;

endpackage

// File: rtl/asi_mode_ctrl.sv
module asi_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trap_i,
  input  logic rett_i,
  output logic super_o,
  output logic saved_o
);

  logic super_q, saved_q;

  // trap entry has priority over return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      super_q <= 1'b1;
      saved_q <= 1'b0;
    end else if (trap_i) begin
      saved_q <= super_q;
      super_q <= 1'b1;
    end else if (rett_i) begin
      super_q <= saved_q;
    end
  end

  assign super_o = super_q;
  assign saved_o = saved_q;

endmodule

// File: rtl/asi_space_decode.sv
module asi_space_decode
  import asi_guard_pkg::*;
#(
  parameter int unsigned ASI_W     = 8,
  parameter int unsigned UINST_ASI = 8'h08,
  parameter int unsigned UDATA_ASI = 8'h09,
  parameter int unsigned PERIPH_ASI = 8'h04,
  parameter int unsigned CTAG_ASI  = 8'h0C,
  parameter int unsigned CDATA_ASI = 8'h0D,
  parameter int unsigned APP_BASE  = 8'h20,
  parameter int unsigned APP_COUNT = 4
) (
  input  logic [ASI_W-1:0] asi_i,
  output logic             user_ok_o,
  output region_e          region_o
);

  localparam int unsigned APP_LAST = APP_BASE + APP_COUNT - 1;

  logic [APP_COUNT-1:0] app_hit;

  for (genvar g = 0; g < APP_COUNT; g++) begin : g_app
    assign app_hit[g] = (asi_i == ASI_W'(APP_BASE + g));
  end

  assign user_ok_o = (asi_i == ASI_W'(UINST_ASI)) || (asi_i == ASI_W'(UDATA_ASI));

  always_comb begin
    region_o = RGN_NONE;
    if      (asi_i == ASI_W'(UINST_ASI))  region_o = RGN_UINST;
    else if (asi_i == ASI_W'(UDATA_ASI))  region_o = RGN_UDATA;
    else if (asi_i == ASI_W'(PERIPH_ASI)) region_o = RGN_PERIPH;
    else if (asi_i == ASI_W'(CTAG_ASI))   region_o = RGN_CTAG;
    else if (asi_i == ASI_W'(CDATA_ASI))  region_o = RGN_CDATA;
    else if (|app_hit)                    region_o = RGN_APP;
  end

  if (APP_LAST >= (1 << ASI_W)) begin : g_bad_range
    initial $error("application range exceeds identifier space");
  end

endmodule

// File: rtl/asi_resp_reg.sv
module asi_resp_reg
  import asi_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              super_i,
  input  logic              user_ok_i,
  input  region_e           region_i,
  output logic              grant_o,
  output logic              viol_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [NUM_STROBES-1:0] strobe_o
);

  logic    allow;
  logic    grant_q, viol_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  region_e region_q;

  assign allow = super_i | user_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      viol_q   <= 1'b0;
      region_q <= RGN_NONE;
      addr_q   <= '0;
      we_q     <= 1'b0;
    end else begin
      grant_q  <= req_i & allow;
      viol_q   <= req_i & ~allow;
      region_q <= (req_i & allow) ? region_i : RGN_NONE;
      if (req_i & allow) begin
        addr_q <= addr_i;
        we_q   <= we_i;
      end
    end
  end

  // strobe index k corresponds to region value k+1
  for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strb
    assign strobe_o[k] = (region_q == region_e'(k + 1));
  end

  assign grant_o = grant_q;
  assign viol_o  = viol_q;
  assign addr_o  = addr_q;
  assign we_o    = we_q;

endmodule

// File: rtl/asi_guard.sv
module asi_guard
  import asi_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned ASI_W     = 8,
  parameter int unsigned UINST_ASI = 8'h08,
  parameter int unsigned UDATA_ASI = 8'h09,
  parameter int unsigned PERIPH_ASI = 8'h04,
  parameter int unsigned CTAG_ASI  = 8'h0C,
  parameter int unsigned CDATA_ASI = 8'h0D,
  parameter int unsigned APP_BASE  = 8'h20,
  parameter int unsigned APP_COUNT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ASI_W-1:0]  asi_i,
  input  logic              trap_i,
  input  logic              rett_i,
  output logic              grant_o,
  output logic              viol_o,
  output logic              super_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              sel_uinst_o,
  output logic              sel_udata_o,
  output logic              sel_periph_o,
  output logic              sel_ctag_o,
  output logic              sel_cdata_o,
  output logic              sel_app_o
);

  logic    super_mode, saved_mode, user_ok;
  region_e region;
  logic [NUM_STROBES-1:0] strobe;

  asi_mode_ctrl u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trap_i  (trap_i),
    .rett_i  (rett_i),
    .super_o (super_mode),
    .saved_o (saved_mode)
  );

  asi_space_decode #(
    .ASI_W      (ASI_W),
    .UINST_ASI  (UINST_ASI),
    .UDATA_ASI  (UDATA_ASI),
    .PERIPH_ASI (PERIPH_ASI),
    .CTAG_ASI   (CTAG_ASI),
    .CDATA_ASI  (CDATA_ASI),
    .APP_BASE   (APP_BASE),
    .APP_COUNT  (APP_COUNT)
  ) u_dec (
    .asi_i     (asi_i),
    .user_ok_o (user_ok),
    .region_o  (region)
  );

  asi_resp_reg #(.ADDR_W(ADDR_W)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .super_i   (super_mode),
    .user_ok_i (user_ok),
    .region_i  (region),
    .grant_o   (grant_o),
    .viol_o    (viol_o),
    .addr_o    (addr_o),
    .we_o      (we_o),
    .strobe_o  (strobe)
  );

  assign super_o      = super_mode;
  assign sel_uinst_o  = strobe[0];
  assign sel_udata_o  = strobe[1];
  assign sel_periph_o = strobe[2];
  assign sel_ctag_o   = strobe[3];
  assign sel_cdata_o  = strobe[4];
  assign sel_app_o    = strobe[5];

endmodule

// File: rtl/asi_guard_chk.sv
module asi_guard_chk #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned ASI_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ASI_W-1:0]  asi_i,
  input logic              trap_i,
  input logic              rett_i,
  input logic              grant_o,
  input logic              viol_o,
  input logic              super_o,
  input logic              saved_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              we_o,
  input logic [5:0]        sel_i
);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (!grant_o && !viol_o && sel_i == '0));

  p_super_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) && $past(super_o)) |-> (grant_o && !viol_o));

  p_viol_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (!grant_o && sel_i == '0));

  p_strobe_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  p_trap_super_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trap_i) |-> super_o);

  p_rett_restore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rett_i && !trap_i) |-> (super_o == $past(saved_i)));

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_o |=> (!grant_o -> $stable(addr_o) && $stable(we_o)));

  p_addr_take_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (addr_o == $past(addr_i) && we_o == $past(we_i)));

  logic unused_asi;
  assign unused_asi = ^asi_i;

endmodule

bind asi_guard asi_guard_chk #(.ADDR_W(ADDR_W), .ASI_W(ASI_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .asi_i   (asi_i),
  .trap_i  (trap_i),
  .rett_i  (rett_i),
  .grant_o (grant_o),
  .viol_o  (viol_o),
  .super_o (super_o),
  .saved_i (saved_mode),
  .addr_o  (addr_o),
  .we_o    (we_o),
  .sel_i   ({sel_app_o, sel_cdata_o, sel_ctag_o, sel_periph_o, sel_udata_o, sel_uinst_o})
);

// File: tb/asi_guard_bench.sv
module asi_guard_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, trap = 1'b0, rett = 1'b0;
  logic [25:0] addr = '0;
  logic [7:0]  asi = '0;
  logic        grant, viol, sup, we_q;
  logic [25:0] addr_q;
  logic s_ui, s_ud, s_pe, s_ct, s_cd, s_ap;

  always #4 clk = ~clk;

  asi_guard u_asi_guard (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .asi_i(asi), .trap_i(trap), .rett_i(rett), .grant_o(grant), .viol_o(viol),
    .super_o(sup), .addr_o(addr_q), .we_o(we_q), .sel_uinst_o(s_ui),
    .sel_udata_o(s_ud), .sel_periph_o(s_pe), .sel_ctag_o(s_ct),
    .sel_cdata_o(s_cd), .sel_app_o(s_ap)
  );

  typedef struct packed {
    logic        grant;
    logic        viol;
    logic        sup;
    logic [5:0]  strb;
    logic [25:0] addr;
    logic        we;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0, n_fail = 0;
  bit    mon_on = 1'b0;

  logic        m_sup = 1'b1, m_saved = 1'b0, m_we = 1'b0;
  logic [25:0] m_addr = '0;

  // strobe order {app, cdata, ctag, periph, udata, uinst}, per R6
  function automatic logic [5:0] strb_of(input logic [7:0] a);
    if (a == 8'h08) return 6'b000001;
    if (a == 8'h09) return 6'b000010;
    if (a == 8'h04) return 6'b000100;
    if (a == 8'h0C) return 6'b001000;
    if (a == 8'h0D) return 6'b010000;
    if (a >= 8'h20 && a <= 8'h23) return 6'b100000;
    return 6'b000000;
  endfunction

  function automatic exp_t observe();
    exp_t o;
    o.grant = grant; o.viol = viol; o.sup = sup;
    o.strb  = {s_ap, s_cd, s_ct, s_pe, s_ud, s_ui};
    o.addr  = addr_q; o.we = we_q;
    return o;
  endfunction

  task automatic check(input string rq, input exp_t act, input exp_t e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: act g=%b v=%b s=%b strb=%b a=%h w=%b exp g=%b v=%b s=%b strb=%b a=%h w=%b",
               rq, act.grant, act.viol, act.sup, act.strb, act.addr, act.we,
               e.grant, e.viol, e.sup, e.strb, e.addr, e.we);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued
  task automatic step(input string rq, input logic r, input logic [7:0] a,
                      input logic [25:0] ad, input logic w,
                      input logic tp, input logic rt);
    exp_t  e;
    logic  ok;
    @(negedge clk);
    req = r; asi = a; addr = ad; we = w; trap = tp; rett = rt;
    ok = r && (m_sup || a == 8'h08 || a == 8'h09);
    if (ok) begin m_addr = ad; m_we = w; end
    if (tp) begin m_saved = m_sup; m_sup = 1'b1; end
    else if (rt) m_sup = m_saved;
    e.grant = ok;
    e.viol  = r && !ok;
    e.sup   = m_sup;
    e.strb  = ok ? strb_of(a) : 6'b0;
    e.addr  = m_addr;
    e.we    = m_we;
    exp_q.push_back(e);
    tag_q.push_back(rq);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #2;
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, observe(), e);
    end
  end

  task automatic drain();
    step("R2", 1'b0, 8'h00, 26'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    exp_t e;
    mon_on = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    req = 0; trap = 0; rett = 0;
    #1;
    e = '{grant:1'b0, viol:1'b0, sup:1'b1, strb:6'b0, addr:26'h0, we:1'b0};
    check("R1", observe(), e);
    @(negedge clk);
    rst_ni = 1'b1;
    m_sup = 1'b1; m_saved = 1'b0; m_addr = '0; m_we = 1'b0;
    check("R1", observe(), e);
    mon_on = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    apply_reset();
    // supervisor sweeps R3/R6
    step("R6", 1, 8'h04, 26'h0000100, 1, 0, 0);
    step("R6", 1, 8'h0C, 26'h0000200, 0, 0, 0);
    step("R6", 1, 8'h0D, 26'h0000300, 1, 0, 0);
    step("R6", 1, 8'h1F, 26'h0000400, 0, 0, 0);
    step("R6", 1, 8'h20, 26'h0000500, 0, 0, 0);
    step("R6", 1, 8'h23, 26'h0000600, 1, 0, 0);
    step("R6", 1, 8'h24, 26'h0000700, 0, 0, 0);
    step("R3", 1, 8'h0A, 26'h0000800, 0, 0, 0);
    step("R3", 1, 8'h0B, 26'h0000900, 1, 0, 0);
    step("R3", 1, 8'h08, 26'h0000A00, 0, 0, 0);
    step("R3", 1, 8'hFF, 26'h3FFFFFF, 1, 0, 0);
    step("R3", 1, 8'h00, 26'h1234567, 0, 0, 0);
    step("R2", 0, 8'h0C, 26'h2AAAAAA, 1, 0, 0);
    // rett after reset drops to user R8
    step("R8", 0, 8'h00, 26'h0, 0, 0, 1);
    step("R4", 1, 8'h08, 26'h0011111, 0, 0, 0);
    step("R4", 1, 8'h09, 26'h0022222, 1, 0, 0);
    step("R5", 1, 8'h0A, 26'h0033333, 1, 0, 0);
    step("R5", 1, 8'h07, 26'h0044444, 0, 0, 0);
    step("R5", 1, 8'h04, 26'h0055555, 1, 0, 0);
    step("R5", 1, 8'h20, 26'h0066666, 0, 0, 0);
    step("R5", 1, 8'h0D, 26'h0077777, 1, 0, 0);
    step("R11", 0, 8'h09, 26'h0088888, 0, 0, 0);
    // request alongside trap judged in user mode R10
    step("R10", 1, 8'h0C, 26'h0099999, 0, 1, 0);
    step("R7", 1, 8'h0C, 26'h00AAAAA, 1, 0, 0);
    // return to user, request in same cycle still supervisor R10
    step("R10", 1, 8'h04, 26'h00BBBBB, 0, 0, 1);
    step("R8", 1, 8'h04, 26'h00CCCCC, 1, 0, 0);
    // both pulses: trap wins R9
    step("R9", 0, 8'h00, 26'h0, 0, 1, 1);
    step("R9", 1, 8'h0D, 26'h00DDDDD, 0, 0, 0);
    // nested trap from supervisor keeps supervisor on return R7
    step("R7", 0, 8'h00, 26'h0, 0, 1, 0);
    step("R8", 0, 8'h00, 26'h0, 0, 0, 1);
    step("R8", 1, 8'h21, 26'h00EEEEE, 1, 0, 0);
    drain();
    // reset mid-run clears saved mode R1
    apply_reset();
    step("R1", 0, 8'h00, 26'h0, 0, 0, 1);
    step("R1", 1, 8'h0C, 26'h00FFFFF, 0, 0, 0);
    step("R4", 1, 8'h09, 26'h0101010, 1, 0, 0);
    drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule